// File: doc/BRIEF.md
# SECDED Protected RAM Controller with Error Reporting

This block places an on-chip word memory behind a single-error-correct, double-error-detect code. Each 16-bit data word is widened to a 22-bit codeword before it is stored, and every read passes the codeword through a syndrome decoder and corrector. Single-bit errors are repaired on the fly, with no stall, and the system keeps running. Double-bit errors are flagged as uncorrectable and their data is never handed on.

Every write is checked as well. In the cycle after a store, the controller reads the same location back and decodes it, so a word that was stored wrongly is caught at once. Any error seen on a read or on a write check is reported to a watchdog port. The report carries the failing address and the class of the error, and stays pending until the watchdog accepts it. An uncorrectable error also raises a sticky halt output. A write-side bit-flip mask lets a test environment plant one or two faulty bits in a stored codeword.

Top module: `secded_ram_ctrl`

## Requirements
- R1: The codeword has 22 bits. Bit 0 makes the parity of all 22 bits even. The check bits sit at positions 1, 2, 4, 8 and 16, and check bit 2^h covers every position whose index has bit h set. The 16 data bits fill the remaining positions in ascending order, so data bit 0 is at position 3.
- R2: A read accepted at a clock edge gives one cycle of rd_valid after the second following edge, with the stored data when the codeword holds no error.
- R3: When exactly one data position (not 0 and not a power of two) is inverted, a read returns the original data with rd_class 01 and rd_uncorr low, and halt stays low.
- R4: When exactly one of the positions 0, 1, 2, 4, 8 or 16 is inverted, a read returns the original data with rd_class 10.
- R5: When two positions are inverted, a read gives rd_class 11, rd_uncorr high and rd_data all zero. halt then rises and stays high until reset.
- R6: busy is high for exactly the one cycle after an accepted write. A request presented while busy is high is ignored: it stores nothing and returns nothing.
- R7: A write whose stored codeword holds an error produces a watchdog report with the write address and the class, without any read. The report appears after the third edge counted from the write edge.
- R8: A pending report keeps wd_valid, wd_addr and wd_class steady until an edge with wd_ready high. If no new error arrives at that edge, wd_valid then falls.
- R9: If an error arrives while a report is pending and not accepted, wd_overflow sets and stays set until reset. The pending report is kept, unless the new error is uncorrectable and the pending one is not; in that case the new error replaces it.
- R10: While reset is held, busy, rd_valid, wd_valid, wd_overflow and halt are all low.
- R11: inj_mask is XORed into the codeword only when a write is stored. On a read it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| inj_mask | input | 22 | Codeword bits to invert on a write (test hook) |
| busy | output | 1 | Write-check cycle in progress |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 16 | Corrected read data; zero when uncorrectable |
| rd_class | output | 2 | 00 none, 01 data bit fixed, 10 check bit fixed, 11 uncorrectable |
| rd_uncorr | output | 1 | Read data is uncorrectable |
| wd_valid | output | 1 | Error report pending |
| wd_ready | input | 1 | Watchdog accepts the report |
| wd_addr | output | ADDR_W | Failing address |
| wd_class | output | 2 | Class of the reported error |
| wd_overflow | output | 1 | Sticky: an error arrived while a report was pending |
| halt | output | 1 | Sticky: an uncorrectable error was seen |

## Verification
A faulty encoder or syndrome table shows up on the first read after a planted fault. The word comes back with the wrong data bit flipped, or with the wrong class, exactly two edges after the request. A wrong pending-report state in the logger shows up at the watchdog port within one edge of the next error or acceptance: a lost address, a downgraded class, or an overflow flag that fails to set or to stay set. Errors in the busy or verify sequencing show up in two ways. An ignored request gets stored, which a later read of that address exposes. Or a write-check report is missing three edges after a faulty store.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int DATA_W = 16;
    localparam int HAM_W  = 5;
    localparam int CW_W   = DATA_W + HAM_W + 1;

    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [1:0] {
        CL_NONE  = 2'b00,
        CL_DATA  = 2'b01,
        CL_CHECK = 2'b10,
        CL_FATAL = 2'b11
    } err_class_e;

    typedef struct packed {
        data_t      data;
        err_class_e cls;
    } dec_t;

    function automatic logic is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    function automatic cw_t encode(input data_t d);
        cw_t c;
        int  k;
        c = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                c[p] = d[k];
                k++;
            end
        end
        for (int h = 0; h < HAM_W; h++) begin
            logic x;
            x = 1'b0;
            for (int p = 1; p < CW_W; p++)
                if (!is_pow2(p) && (((p >> h) & 1) == 1)) x ^= c[p];
            c[1 << h] = x;
        end
        c[0] = ^c[CW_W-1:1];
        return c;
    endfunction

    function automatic logic [HAM_W-1:0] syndrome(input cw_t c);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int p = 1; p < CW_W; p++)
            if (c[p]) s ^= HAM_W'(p);
        return s;
    endfunction

    function automatic dec_t decode(input cw_t c);
        dec_t             r;
        cw_t              fixed;
        logic [HAM_W-1:0] s;
        logic             odd;
        int               k;
        s     = syndrome(c);
        odd   = ^c;
        fixed = c;
        if (s == '0) begin
            r.cls = odd ? CL_CHECK : CL_NONE;
        end else if (odd && (int'(s) < CW_W)) begin
            fixed[int'(s)] = ~fixed[int'(s)];
            r.cls = is_pow2(int'(s)) ? CL_CHECK : CL_DATA;
        end else begin
            r.cls = CL_FATAL;
        end
        r.data = '0;
        k = 0;
        for (int p = 1; p < CW_W; p++) begin
            if (!is_pow2(p)) begin
                r.data[k] = fixed[p];
                k++;
            end
        end
        if (r.cls == CL_FATAL) r.data = '0;
        return r;
    endfunction
endpackage

// File: rtl/secded_mem.sv
module secded_mem
    import secded_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  cw_t               wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output cw_t               rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    cw_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/secded_log.sv
module secded_log
    import secded_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  err_class_e        ev_cls,
    input  logic              wd_ready,
    output logic              wd_valid,
    output logic [ADDR_W-1:0] wd_addr,
    output err_class_e        wd_cls,
    output logic              wd_overflow,
    output logic              halt
);
    logic take;
    assign take = ev_valid &&
                  (!wd_valid || wd_ready ||
                   (ev_cls == CL_FATAL && wd_cls != CL_FATAL));

    always_ff @(posedge clk) begin
        if (rst) begin
            wd_valid    <= 1'b0;
            wd_addr     <= '0;
            wd_cls      <= CL_NONE;
            wd_overflow <= 1'b0;
            halt        <= 1'b0;
        end else begin
            if (take) begin
                wd_valid <= 1'b1;
                wd_addr  <= ev_addr;
                wd_cls   <= ev_cls;
            end else if (wd_valid && wd_ready) begin
                wd_valid <= 1'b0;
            end
            if (ev_valid && wd_valid && !wd_ready) wd_overflow <= 1'b1;
            if (ev_valid && ev_cls == CL_FATAL) halt <= 1'b1;
        end
    end

    p_hold_valid_r8: assert property (@(posedge clk) disable iff (rst)
        wd_valid && !wd_ready |=> wd_valid);
    p_hold_fields_r8: assert property (@(posedge clk) disable iff (rst)
        wd_valid && !wd_ready && !ev_valid |=> $stable(wd_addr) && $stable(wd_cls));
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        wd_overflow |=> wd_overflow);
    p_fatal_kept_r9: assert property (@(posedge clk) disable iff (rst)
        wd_valid && !wd_ready && wd_cls == CL_FATAL |=> wd_cls == CL_FATAL);
    p_halt_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);
endmodule

// File: rtl/secded_ram_ctrl.sv
module secded_ram_ctrl
    import secded_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [21:0]       inj_mask,
    output logic              busy,
    output logic              rd_valid,
    output logic [15:0]       rd_data,
    output logic [1:0]        rd_class,
    output logic              rd_uncorr,
    output logic              wd_valid,
    input  logic              wd_ready,
    output logic [ADDR_W-1:0] wd_addr,
    output logic [1:0]        wd_class,
    output logic              wd_overflow,
    output logic              halt
);
    logic              accept, mem_we, mem_re;
    logic [ADDR_W-1:0] mem_raddr, vfy_addr_q, s1_addr;
    logic              vfy_q, s1_valid, s1_is_rd;
    cw_t               mem_wdata, mem_rdata;
    dec_t              dec;
    err_class_e        log_cls;

    assign accept    = req_valid && !vfy_q;
    assign mem_we    = accept && req_we;
    assign mem_wdata = encode(req_wdata) ^ inj_mask;
    assign mem_re    = (accept && !req_we) || vfy_q;
    assign mem_raddr = vfy_q ? vfy_addr_q : req_addr;
    assign busy      = vfy_q;

    secded_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (req_addr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vfy_q      <= 1'b0;
            vfy_addr_q <= '0;
            s1_valid   <= 1'b0;
            s1_is_rd   <= 1'b0;
            s1_addr    <= '0;
        end else begin
            vfy_q      <= mem_we;
            vfy_addr_q <= req_addr;
            s1_valid   <= mem_re;
            s1_is_rd   <= !vfy_q;
            s1_addr    <= mem_raddr;
        end
    end

    assign dec = decode(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            rd_class  <= 2'b00;
            rd_uncorr <= 1'b0;
        end else begin
            rd_valid  <= s1_valid && s1_is_rd;
            rd_data   <= dec.data;
            rd_class  <= dec.cls;
            rd_uncorr <= s1_valid && s1_is_rd && (dec.cls == CL_FATAL);
        end
    end

    secded_log #(.ADDR_W(ADDR_W)) u_log (
        .clk         (clk),
        .rst         (rst),
        .ev_valid    (s1_valid && dec.cls != CL_NONE),
        .ev_addr     (s1_addr),
        .ev_cls      (dec.cls),
        .wd_ready    (wd_ready),
        .wd_valid    (wd_valid),
        .wd_addr     (wd_addr),
        .wd_cls      (log_cls),
        .wd_overflow (wd_overflow),
        .halt        (halt)
    );
    assign wd_class = log_cls;

    p_busy_single_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
    p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_we && !busy |=> ##1 rd_valid);
    p_busy_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        busy |=> ##1 !rd_valid);
    p_uncorr_blank_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid && rd_class == 2'b11 |-> rd_uncorr && rd_data == '0);
endmodule

// File: tb/tb_secded_ram_ctrl.sv
module tb_secded_ram_ctrl;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [21:0]   inj_mask = '0;
    logic          wd_ready = 1'b0;
    logic          busy, rd_valid, rd_uncorr, wd_valid, wd_overflow, halt;
    logic [15:0]   rd_data;
    logic [1:0]    rd_class, wd_class;
    logic [AW-1:0] wd_addr;

    always #5 clk = ~clk;

    secded_ram_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .inj_mask(inj_mask),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_class(rd_class),
        .rd_uncorr(rd_uncorr), .wd_valid(wd_valid), .wd_ready(wd_ready),
        .wd_addr(wd_addr), .wd_class(wd_class), .wd_overflow(wd_overflow),
        .halt(halt)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    logic [15:0] mdata [64];
    logic [21:0] mmask [64];

    // two-deep queue of expected read results
    bit          cur_v, p1_v, p2_v;
    logic [15:0] cur_d, p1_d, p2_d;
    logic [1:0]  cur_c, p1_c, p2_c;

    function automatic logic [1:0] exp_cls(input logic [21:0] m);
        int n;
        int pos;
        n = $countones(m);
        pos = 0;
        if (n == 0) return 2'b00;
        if (n > 1) return 2'b11;
        for (int i = 0; i < 22; i++) if (m[i]) pos = i;
        if (pos == 0 || (pos & (pos - 1)) == 0) return 2'b10;
        return 2'b01;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        p2_v = p1_v; p2_d = p1_d; p2_c = p1_c;
        p1_v = cur_v; p1_d = cur_d; p1_c = cur_c;
        cur_v = 0;
        if (p2_v || rd_valid) begin
            check(rd_valid == p2_v, "R2", "rd_valid", rd_valid, p2_v);
            if (p2_v) begin
                check(rd_data == p2_d, "R2/R3/R5", "rd_data", rd_data, p2_d);
                check(rd_class == p2_c, "R3/R4/R5", "rd_class", rd_class, p2_c);
                check(rd_uncorr == (p2_c == 2'b11), "R5", "rd_uncorr", rd_uncorr, p2_c == 2'b11);
            end
        end
    endtask

    task automatic idle();
        req_valid = 0; req_we = 0; inj_mask = '0;
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input logic [21:0] m);
        req_valid = 1; req_we = 1; req_addr = AW'(a); req_wdata = d; inj_mask = m;
        mdata[a] = d; mmask[a] = m;
        tick();
        check(busy == 1'b1, "R6", "busy after write", busy, 1);
        idle();
        tick();
        check(busy == 1'b0, "R6", "busy drops", busy, 0);
    endtask

    task automatic do_read(input int a, input logic [21:0] m);
        req_valid = 1; req_we = 0; req_addr = AW'(a); inj_mask = m;
        cur_v = 1;
        cur_c = exp_cls(mmask[a]);
        cur_d = (cur_c == 2'b11) ? 16'h0 : mdata[a];
        tick();
        idle();
    endtask

    task automatic chk_log(input bit v, input int a, input logic [1:0] c,
                           input bit ovf, input bit h, input string req);
        check(wd_valid == v, req, "wd_valid", wd_valid, v);
        if (v) begin
            check(wd_addr == AW'(a), req, "wd_addr", wd_addr, a);
            check(wd_class == c, req, "wd_class", wd_class, c);
        end
        check(wd_overflow == ovf, req, "wd_overflow", wd_overflow, ovf);
        check(halt == h, req, "halt", halt, h);
    endtask

    task automatic ack();
        wd_ready = 1;
        tick();
        wd_ready = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cur_v = 0; p1_v = 0; p2_v = 0;
        cur_d = '0; p1_d = '0; p2_d = '0; cur_c = '0; p1_c = '0; p2_c = '0;
        for (int i = 0; i < 64; i++) begin mdata[i] = '0; mmask[i] = '0; end
        tick(); tick();
        // R10 reset state
        check(busy == 0 && rd_valid == 0, "R10", "busy/rd_valid", {busy, rd_valid}, 0);
        chk_log(0, 0, 0, 0, 0, "R10");
        rst = 0;
        tick();

        // clean writes and reads (R1, R2)
        do_write(1, 16'hA5C3, '0);
        do_write(2, 16'hFFFF, '0);
        do_write(3, 16'h0000, '0);
        do_write(4, 16'h1234, '0);
        tick();
        chk_log(0, 0, 0, 0, 0, "R1");
        do_read(1, '0); do_read(2, '0); do_read(3, '0); do_read(4, '0);
        tick(); tick();
        chk_log(0, 0, 0, 0, 0, "R2");

        // R11: mask on a read is ignored
        do_read(4, 22'h00_0108);
        tick(); tick();
        chk_log(0, 0, 0, 0, 0, "R11");

        // R7/R3: single data flip at position 3
        do_write(5, 16'hBEEF, 22'h00_0008);
        tick();
        chk_log(1, 5, 2'b01, 0, 0, "R7");
        tick(); tick();
        chk_log(1, 5, 2'b01, 0, 0, "R8");
        ack();
        chk_log(0, 0, 0, 0, 0, "R8");
        do_read(5, '0);
        tick();
        chk_log(1, 5, 2'b01, 0, 0, "R3");
        ack();

        // R4: check-bit flip at 8 and overall parity flip at 0
        do_write(6, 16'h5A5A, 22'h00_0100);
        tick();
        chk_log(1, 6, 2'b10, 0, 0, "R4");
        ack();
        do_read(6, '0);
        tick();
        ack();
        do_write(7, 16'h0F0F, 22'h00_0001);
        tick();
        chk_log(1, 7, 2'b10, 0, 0, "R4");
        ack();
        do_read(7, '0);
        tick();
        ack();

        // R9 overflow and fatal replacement, R5 double error
        do_write(8, 16'h1111, 22'h00_0020);
        tick();
        chk_log(1, 8, 2'b01, 0, 0, "R9");
        do_write(9, 16'h2222, 22'h00_0040);
        tick();
        chk_log(1, 8, 2'b01, 1, 0, "R9");
        do_write(10, 16'h3333, 22'h00_0208);
        tick();
        chk_log(1, 10, 2'b11, 1, 1, "R9");
        do_write(11, 16'h4444, 22'h00_0020);
        tick();
        chk_log(1, 10, 2'b11, 1, 1, "R9");
        ack();
        chk_log(0, 0, 0, 1, 1, "R8");
        do_read(10, '0);
        tick();
        chk_log(1, 10, 2'b11, 1, 1, "R5");
        ack();

        // R6: request during busy is ignored
        req_valid = 1; req_we = 1; req_addr = AW'(1); req_wdata = 16'h7777; inj_mask = '0;
        mdata[1] = 16'h7777;
        tick();
        check(busy == 1'b1, "R6", "busy", busy, 1);
        req_addr = AW'(2); req_wdata = 16'hDEAD;
        tick();
        idle();
        tick();
        do_read(2, '0);
        do_read(1, '0);
        tick(); tick();
        chk_log(0, 0, 0, 1, 1, "R6");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule